// File: doc/BRIEF.md
# Wide-Result Unsigned Multiply-Accumulate Unit

This unit takes three unsigned operands of equal width, multiplies the first two into a product twice that width, and adds the third to the product after padding it with zeros. The sum always fits in the doubled width. Its lower and upper halves leave the unit on two separate ports. The upper half is meant to be fed back as the addend of the next step, so that a chain of these steps multiplies a long multi-word number by one word.

Operands are accepted with a valid/ready handshake. The unit is fully pipelined, so it can accept one operand set on every cycle. Each accepted set produces exactly one result pulse after a fixed three-cycle latency, and results leave in the order their operands were accepted. The word width is a parameter. Its default is 64, and it must be even.

Top module: `fma_wide`

## Requirements
- R1: The unit forms the full unsigned product of `in_a` and `in_b`, 2W bits wide, with no truncation and no sign interpretation.
- R2: `in_c` is zero-extended to 2W bits and added to the product unshifted. A set most significant bit of `in_c` adds 2^(W-1), never a negative value.
- R3: `out_lo` carries bits W-1..0 of the 2W-bit sum.
- R4: `out_hi` carries bits 2W-1..W of the 2W-bit sum.
- R5: The sum never overflows. When every operand bit is one, `out_hi` is all ones and `out_lo` is zero. Whenever `out_hi` is all ones, `out_lo` is zero.
- R6: A result is valid exactly three rising clock edges after the edge at which `in_valid` and `in_ready` were both high.
- R7: After reset, `in_ready` stays high, and a new operand set can be accepted on every cycle. Each accepted set yields exactly one `out_valid` pulse, in acceptance order.
- R8: While `rst` is high, and in the first cycle after it, `in_ready` and `out_valid` are low. `rst` is synchronous and active high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand set present |
| in_ready | output | 1 | Unit can take an operand set |
| in_a | input | W | Multiplicand |
| in_b | input | W | Multiplier |
| in_c | input | W | Addend, zero-extended |
| out_valid | output | 1 | Result pulse |
| out_lo | output | W | Lower half of the sum |
| out_hi | output | W | Upper half of the sum |

## Verification
A wrong partial-product alignment or a dropped cross-term carry would show up as a wrong `out_hi` or `out_lo` three cycles after the faulty operands go in. The exhaustive 8-bit sweep finds it on the first affected operand pair. A valid bit lost or duplicated in the pipeline would show up as a missing or surplus result pulse. Because results are compared in order against a queue, that same error also shifts every later result. Treating the addend as signed would be seen only when its top bit is set, and the all-ones corners make that case appear at once.

// File: rtl/fma_wide.sv
module fma_wide #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  input  logic [W-1:0] in_c,
  output logic         out_valid,
  output logic [W-1:0] out_lo,
  output logic [W-1:0] out_hi
);
  localparam int H = W / 2;
  localparam int D = 2 * W;

  logic fire;
  assign fire = in_valid & in_ready;

  always_ff @(posedge clk)
    if (rst) in_ready <= 1'b0;
    else     in_ready <= 1'b1;

  logic         s1_v;
  logic [W-1:0] pp_ll, pp_lh, pp_hl, pp_hh, s1_c;

  always_ff @(posedge clk) begin
    if (rst) s1_v <= 1'b0;
    else     s1_v <= fire;
    if (fire) begin
      pp_ll <= W'(in_a[H-1:0]) * W'(in_b[H-1:0]);
      pp_lh <= W'(in_a[H-1:0]) * W'(in_b[W-1:H]);
      pp_hl <= W'(in_a[W-1:H]) * W'(in_b[H-1:0]);
      pp_hh <= W'(in_a[W-1:H]) * W'(in_b[W-1:H]);
      s1_c  <= in_c;
    end
  end

  logic         s2_v;
  logic [D-1:0] s2_sum, sum_c;

  assign sum_c = {pp_hh, pp_ll}
               + ({{W{1'b0}}, pp_lh} << H)
               + ({{W{1'b0}}, pp_hl} << H)
               + {{W{1'b0}}, s1_c};

  always_ff @(posedge clk) begin
    if (rst) s2_v <= 1'b0;
    else     s2_v <= s1_v;
    if (s1_v) s2_sum <= sum_c;
  end

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= s2_v;
    if (s2_v) begin
      out_lo <= s2_sum[W-1:0];
      out_hi <= s2_sum[D-1:W];
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> !out_valid && !in_ready);  // R8

  AST_READY_HELD: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> in_ready);  // R7

  AST_LATENCY: assert property (@(posedge clk) disable iff (rst)
    fire |-> ##3 out_valid);  // R6

  AST_PULSE_SOURCE: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(fire, 3));  // R7

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_hi == {W{1'b1}}) |-> out_lo == {W{1'b0}});  // R5

  AST_RESULT: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> {out_hi, out_lo} ==
      ({{W{1'b0}}, $past(in_a, 3)} * {{W{1'b0}}, $past(in_b, 3)}
       + {{W{1'b0}}, $past(in_c, 3)}));  // R1 R2 R3 R4
endmodule

// File: tb/fma_wide_test.sv
module fma_wide_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        v64 = 1'b0, v8 = 1'b0;
  logic [63:0] a64 = '0, b64 = '0, c64 = '0;
  logic [7:0]  a8 = '0, b8 = '0, c8 = '0;
  logic        r64, r8, ov64, ov8;
  logic [63:0] lo64, hi64;
  logic [7:0]  lo8, hi8;

  fma_wide #(.W(64)) uut (.clk(clk), .rst(rst), .in_valid(v64), .in_ready(r64),
    .in_a(a64), .in_b(b64), .in_c(c64), .out_valid(ov64), .out_lo(lo64), .out_hi(hi64));
  fma_wide #(.W(8)) uut_small (.clk(clk), .rst(rst), .in_valid(v8), .in_ready(r8),
    .in_a(a8), .in_b(b8), .in_c(c8), .out_valid(ov8), .out_lo(lo8), .out_hi(hi8));

  int checks = 0, fails = 0;
  bit done = 0;
  logic [127:0] q64[$];
  logic [15:0]  q8[$];

  task automatic chk(input bit ok, input string what, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  always @(negedge clk) if (!rst) begin
    if (ov64) begin
      if (q64.size() == 0) chk(0, "R7 surplus pulse 64", 1, 0);
      else begin
        logic [127:0] e;
        e = q64.pop_front();
        chk(lo64 == e[63:0], "R3 R1 R2 lo 64", lo64, e[63:0]);
        chk(hi64 == e[127:64], "R4 R1 R2 hi 64", hi64, e[127:64]);
      end
    end
    if (ov8) begin
      if (q8.size() == 0) chk(0, "R7 surplus pulse 8", 1, 0);
      else begin
        logic [15:0] e;
        e = q8.pop_front();
        chk({hi8, lo8} == e, "R1 R2 R3 R4 sum 8", {hi8, lo8}, e);
      end
    end
  end

  task automatic drive64(input logic [63:0] a, input logic [63:0] b, input logic [63:0] c);
    a64 = a; b64 = b; c64 = c; v64 = 1'b1;
    q64.push_back({64'b0, a} * {64'b0, b} + {64'b0, c});
    @(negedge clk);
    v64 = 1'b0;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL R7 watchdog expired actual=hung expected=finished");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!ov64 && !r64 && !ov8 && !r8, "R8 reset state", {ov64, r64, ov8, r8}, 0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!ov64 && !ov8, "R8 no pulse after reset", {ov64, ov8}, 0);
    chk(r64 && r8, "R7 ready after reset", {r64, r8}, 2'b11);

    // R6 isolated vector latency
    begin
      int k;
      k = 0;
      a64 = 64'd3; b64 = 64'd5; c64 = 64'd7; v64 = 1'b1;
      q64.push_back(128'd22);
      do begin
        @(negedge clk);
        v64 = 1'b0;
        k++;
      end while (!ov64 && k < 10);
      chk(k == 3, "R6 latency", k, 3);
    end
    repeat (4) @(negedge clk);

    // R5 all-ones corners, back-to-back (R7)
    drive64('1, '1, '1);
    drive64('1, '1, '0);
    drive64('0, '1, '1);
    drive64(64'h8000_0000_0000_0000, 64'd1, 64'h8000_0000_0000_0000);
    drive64(64'd0, 64'd0, 64'h8000_0000_0000_0001);
    drive64(64'h0000_0001_0000_0000, 64'h0000_0001_0000_0000, 64'd0);
    repeat (4) @(negedge clk);
    chk(q64.size() == 0, "R7 corner pulses", q64.size(), 0);

    // direct R5 check at the ports
    a64 = '1; b64 = '1; c64 = '1; v64 = 1'b1;
    q64.push_back({64'b0, a64} * {64'b0, b64} + {64'b0, c64});
    @(negedge clk); v64 = 1'b0;
    @(negedge clk); @(negedge clk);
    chk(ov64 && hi64 == '1 && lo64 == '0, "R5 all ones", {hi64, lo64}, {64'hFFFF_FFFF_FFFF_FFFF, 64'h0});
    repeat (4) @(negedge clk);

    for (int i = 0; i < 3000; i++)
      drive64({$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom});
    repeat (5) @(negedge clk);
    chk(q64.size() == 0, "R7 random pulses drained", q64.size(), 0);

    // exhaustive 8-bit operand sweep, one set per cycle
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b++) begin
        logic [7:0] c;
        c = 8'(a * 37 + b * 11) ^ 8'(b);
        if (b == 255) c = 8'hFF;
        a8 = 8'(a); b8 = 8'(b); c8 = c; v8 = 1'b1;
        q8.push_back(16'(a) * 16'(b) + {8'b0, c});
        @(negedge clk);
      end
    v8 = 1'b0;
    repeat (5) @(negedge clk);
    chk(q8.size() == 0, "R7 sweep pulses drained", q8.size(), 0);
    summary();
  end
endmodule